// File: doc/BRIEF.md
# Integer and Short-Float Converter

This block translates numbers in both directions between 16-bit two's-complement integers and a compact 27-bit floating-point word. The float word has a sign bit, an 8-bit exponent biased by 127 and an 18-bit fraction with an implied leading one. Arithmetic pipelines that work in the short float format use it to bring integer samples in and to hand integer results back out.

The two directions are separate combinational paths with their own input and output ports, so both can be used in the same cycle. Integer-to-float is always exact, because every 16-bit magnitude fits in the 19-bit significand. Float-to-integer drops any fractional part, which truncates toward zero. Magnitudes that do not fit clamp to plus or minus 32767. The block holds no state and has no clock, no reset and no state machine.

Top module: `fxc_convert`

## Requirements
- R1: The float word puts the sign in bit 26, the biased exponent in bits 25:18 and the fraction in bits 17:0. A nonzero exponent field e stands for (-1)^sign * (1 + fraction/2^18) * 2^(e-127).
- R2: Integer input 0 produces the all-zero float word, and no other integer produces it.
- R3: A nonzero integer x produces exponent field 127+p, where p is the bit position of the most significant one in |x|. The fraction holds the bits of |x| below that one, left-aligned, so the conversion is exact.
- R4: The sign bit of the float output equals bit 15 of the integer input.
- R5: Integer -32768 (0x8000) produces the float word with sign 1, exponent field 142 and fraction 0, which is 0x6380000.
- R6: A float with exponent field 0 produces integer 0, whatever its sign and fraction.
- R7: A float with exponent field 1 to 126 (magnitude below 1) produces integer 0.
- R8: A float with exponent field 127 to 141 produces its value truncated toward zero, as a two's-complement integer.
- R9: A float with exponent field 142 or more produces +32767 (0x7FFF) when the sign is 0 and -32767 (0x8001) when the sign is 1. The output is never 0x8000.
- R10: Each output depends only on its own input, and it settles within the cycle in which that input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_word_i | input | 16 | Two's-complement integer to convert to float |
| flt_word_o | output | 27 | Float result of int_word_i |
| flt_word_i | input | 27 | Float word to convert to integer |
| int_word_o | output | 16 | Truncated, saturated integer result of flt_word_i |

## Verification
The hardest region to reach is the narrow band of float exponents around 142. There the integer output switches from exact truncation to saturation, and a uniformly random 27-bit word almost never lands in it. The stimulus therefore draws exponent fields mostly from 110 to 149, so it crosses the underflow, truncation and saturation boundaries many times. It adds directed words at fields 126, 127, 141, 142 and 255, and at field 0 with a nonzero fraction. On the integer side, -32768, +/-1 and the powers of two are driven directly, because random values reach them rarely.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
    parameter int FXC_INT_W  = 16;
    parameter int FXC_EXP_W  = 8;
    parameter int FXC_FRAC_W = 18;
    parameter int FXC_BIAS   = 127;
    localparam int FXC_FLT_W = 1 + FXC_EXP_W + FXC_FRAC_W;

    typedef struct packed {
        logic                  sign;
        logic [FXC_EXP_W-1:0]  expo;
        logic [FXC_FRAC_W-1:0] frac;
    } fxc_flt_t;
endpackage

// File: rtl/fxc_lead_one.sv
module fxc_lead_one #(
    parameter int W  = 16,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [PW-1:0] idx_o,
    output logic          found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o   = PW'(i);
                found_o = 1'b1;
            end
        end
    end

    always_comb begin
        if (found_o) begin
            a_r3_top_bit_set: assert (vec_i[idx_o])
                else $error("leading-one index does not point at a set bit");
        end
    end
endmodule

// File: rtl/fxc_int_to_flt.sv
module fxc_int_to_flt
    import fxc_pkg::*;
#(
    parameter int INT_W  = FXC_INT_W,
    parameter int EXP_W  = FXC_EXP_W,
    parameter int FRAC_W = FXC_FRAC_W,
    parameter int BIAS   = FXC_BIAS,
    localparam int POS_W = $clog2(INT_W),
    localparam int PAD_W = FRAC_W - INT_W + 1
) (
    input  logic [INT_W-1:0]       int_i,
    output logic [FRAC_W+EXP_W:0]  flt_o
);
    logic              neg;
    logic [INT_W-1:0]  mag;
    logic [INT_W-1:0]  aligned;
    logic [POS_W-1:0]  pos;
    logic              nonzero;

    assign neg = int_i[INT_W-1];
    assign mag = neg ? (~int_i + 1'b1) : int_i;

    fxc_lead_one #(.W(INT_W)) lead_i (
        .vec_i  (mag),
        .idx_o  (pos),
        .found_o(nonzero)
    );

    always_comb begin
        aligned = mag << (POS_W'(INT_W - 1) - pos);
        if (nonzero) begin
            flt_o = {neg,
                     EXP_W'(BIAS) + EXP_W'(pos),
                     aligned[INT_W-2:0], {PAD_W{1'b0}}};
        end else begin
            flt_o = '0;
        end
    end

    always_comb begin
        a_r2_zero_word: assert ((flt_o == '0) == (int_i == '0))
            else $error("zero float word not tied to zero integer");
        if (int_i != '0) begin
            a_r4_sign_follows: assert (flt_o[FRAC_W+EXP_W] == int_i[INT_W-1])
                else $error("float sign differs from integer sign");
            a_r3_exp_range: assert (flt_o[FRAC_W+EXP_W-1:FRAC_W] >= EXP_W'(BIAS) &&
                                    flt_o[FRAC_W+EXP_W-1:FRAC_W] <  EXP_W'(BIAS + INT_W))
                else $error("exponent outside integer range");
        end
    end
endmodule

// File: rtl/fxc_flt_to_int.sv
module fxc_flt_to_int
    import fxc_pkg::*;
#(
    parameter int INT_W  = FXC_INT_W,
    parameter int EXP_W  = FXC_EXP_W,
    parameter int FRAC_W = FXC_FRAC_W,
    parameter int BIAS   = FXC_BIAS,
    localparam int SIG_W = FRAC_W + 1,
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}}
) (
    input  logic [FRAC_W+EXP_W:0] flt_i,
    output logic [INT_W-1:0]      int_o
);
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [SIG_W-1:0]  sig;
    logic [SIG_W-1:0]  shifted;
    logic [INT_W-1:0]  mag;
    int                unb;

    assign sign = flt_i[FRAC_W+EXP_W];
    assign expo = flt_i[FRAC_W+EXP_W-1:FRAC_W];
    assign sig  = {1'b1, flt_i[FRAC_W-1:0]};

    always_comb begin
        unb     = int'(expo) - BIAS;
        shifted = '0;
        mag     = '0;
        if (expo == '0 || unb < 0) begin
            mag = '0;
        end else if (unb >= INT_W - 1) begin
            mag = SAT_POS;
        end else begin
            shifted = sig >> (FRAC_W - unb);
            mag     = shifted[INT_W-1:0];
        end
        int_o = sign ? (~mag + 1'b1) : mag;
    end

    always_comb begin
        a_r9_no_most_negative: assert (int_o != {1'b1, {(INT_W-1){1'b0}}})
            else $error("most negative integer produced");
        if (expo == '0) begin
            a_r6_zero_exp: assert (int_o == '0)
                else $error("zero exponent gave nonzero integer");
        end
        if (int_o != '0) begin
            a_r8_sign_kept: assert (int_o[INT_W-1] == sign)
                else $error("integer sign differs from float sign");
        end
    end
endmodule

// File: rtl/fxc_convert.sv
module fxc_convert
    import fxc_pkg::*;
#(
    parameter int INT_W  = FXC_INT_W,
    parameter int EXP_W  = FXC_EXP_W,
    parameter int FRAC_W = FXC_FRAC_W,
    parameter int BIAS   = FXC_BIAS,
    localparam int FLT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [INT_W-1:0] int_word_i,
    output logic [FLT_W-1:0] flt_word_o,
    input  logic [FLT_W-1:0] flt_word_i,
    output logic [INT_W-1:0] int_word_o
);
    fxc_int_to_flt #(
        .INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
    ) fwd_i (
        .int_i(int_word_i),
        .flt_o(flt_word_o)
    );

    fxc_flt_to_int #(
        .INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
    ) rev_i (
        .flt_i(flt_word_i),
        .int_o(int_word_o)
    );
endmodule

// File: tb/fxc_convert_tb.sv
module fxc_convert_tb_top;
    logic        clk = 1'b0;
    logic [15:0] int_in = '0;
    logic [26:0] flt_out;
    logic [26:0] flt_in = '0;
    logic [15:0] int_out;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    fxc_convert dut_i (
        .int_word_i(int_in),
        .flt_word_o(flt_out),
        .flt_word_i(flt_in),
        .int_word_o(int_out)
    );

    function automatic logic [26:0] exp_flt(input logic [15:0] x);
        int v, m, p;
        v = int'($signed(x));
        m = (v < 0) ? -v : v;
        if (m == 0) return '0;
        p = $clog2(m + 1) - 1;
        return {x[15], 8'(127 + p), 18'((m - (1 << p)) * (1 << (18 - p)))};
    endfunction

    function automatic logic [15:0] exp_int(input logic [26:0] f);
        real v;
        int  e, r;
        e = int'(f[25:18]);
        if (e == 0) return '0;
        v = 1.0 + real'(f[17:0]) / 262144.0;
        for (int k = 0; k < e - 127; k++) v = v * 2.0;
        for (int k = 0; k < 127 - e; k++) v = v / 2.0;
        if (v >= 32768.0) r = 32767;
        else r = $rtoi(v);
        if (f[26]) r = -r;
        return 16'(r);
    endfunction

    task automatic run_i2f(input logic [15:0] x, input string req);
        @(posedge clk);
        int_in = x;
        @(negedge clk);
        n_run++;
        if (flt_out !== exp_flt(x)) begin
            n_fail++;
            $display("FAIL %s int=%h flt actual=%h expected=%h", req, x, flt_out, exp_flt(x));
        end
    endtask

    task automatic run_f2i(input logic [26:0] f, input string req);
        @(posedge clk);
        flt_in = f;
        @(negedge clk);
        n_run++;
        if (int_out !== exp_int(f)) begin
            n_fail++;
            $display("FAIL %s flt=%h int actual=%h expected=%h", req, f, int_out, exp_int(f));
        end
    endtask

    task automatic chk_val(input logic [31:0] act, input logic [31:0] expv, input string req);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    initial begin
        logic [15:0] held_i;
        logic [26:0] held_f;
        void'($urandom(32'd5760));
        @(negedge clk);
        chk_val(32'(flt_out), 32'h0, "R2 idle float output");
        chk_val(32'(int_out), 32'h0, "R6 idle integer output");

        run_i2f(16'h0000, "R2");
        run_i2f(16'h0001, "R3");
        run_i2f(16'hFFFF, "R4");
        run_i2f(16'h7FFF, "R3");
        run_i2f(16'h8000, "R5");
        chk_val(32'(flt_out), 32'h6380000, "R5 literal word");
        run_i2f(16'h8001, "R4");
        for (int b = 0; b < 15; b++) begin
            run_i2f(16'(1 << b), "R3 power of two");
            run_i2f(16'(-(1 << b)), "R4 negative power");
        end

        run_f2i({1'b1, 8'd0, 18'h3FFFF}, "R6");
        run_f2i({1'b0, 8'd0, 18'h00001}, "R6");
        run_f2i({1'b0, 8'd126, 18'h3FFFF}, "R7");
        run_f2i({1'b1, 8'd1, 18'h0}, "R7");
        run_f2i({1'b0, 8'd127, 18'h0}, "R8");
        run_f2i({1'b1, 8'd127, 18'h3FFFF}, "R8");
        run_f2i({1'b0, 8'd128, 18'h20000}, "R8");
        run_f2i({1'b1, 8'd141, 18'h3FFFF}, "R8");
        chk_val(32'(int_out), 32'(16'h8001), "R8 -32767 from truncation");
        run_f2i({1'b0, 8'd142, 18'h0}, "R9");
        chk_val(32'(int_out), 32'h7FFF, "R9 positive clamp");
        run_f2i({1'b1, 8'd142, 18'h0}, "R9");
        chk_val(32'(int_out), 32'h8001, "R9 negative clamp");
        run_f2i({1'b1, 8'd255, 18'h3FFFF}, "R9");
        run_f2i(exp_flt(16'h1234), "R1 round trip");

        for (int n = 0; n < 400; n++) begin
            run_i2f(16'($urandom), "R3 random");
            run_f2i({1'($urandom), 8'(110 + $urandom % 40), 18'($urandom)}, "R8 random");
        end

        // R10: each path ignores the other input
        @(posedge clk);
        int_in = 16'h0123;
        flt_in = {1'b0, 8'd133, 18'h12345};
        @(negedge clk);
        held_i = int_out;
        held_f = flt_out;
        @(posedge clk);
        int_in = 16'hBEEF;
        @(negedge clk);
        chk_val(32'(int_out), 32'(held_i), "R10 integer output kept");
        chk_val(32'(flt_out), 32'(exp_flt(16'hBEEF)), "R10 float output same cycle");
        @(posedge clk);
        flt_in = {1'b1, 8'd120, 18'h0};
        @(negedge clk);
        chk_val(32'(flt_out), 32'(exp_flt(16'hBEEF)), "R10 float output kept");
        chk_val(32'(int_out), 32'h0, "R10 integer output same cycle");
        if (held_f == '1) $display("unreachable");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule